// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 peripheral interrupt requests and picks one to present to a processor. A request is taken only when all of these hold: a rising edge has been captured for the source, the source is enabled, the global mask is clear, its priority is below the base threshold, and no source is already in service. Among the requests that qualify, the one with the smallest priority value wins. On a tie, the lowest source index wins. The selected source is presented with its exception number and the address of its vector-table slot.

Software configures the block through a single-cycle write port. A select code on that port chooses one of five actions: set-enable, clear-enable, per-source priority, global mask, or base threshold. The processor takes a presented request by pulsing the acknowledge input. The source then stays in service until the end-of-service input is pulsed, so the block supports one level of service and no nesting.

Top module: `irqv_top`

## Requirements
- R1: After reset, every source is disabled, every priority is 0, the global mask and threshold are 0, nothing is in service, and `req_valid`, `exc_num` and `vec_addr` are all 0. A request from a disabled source is never presented.
- R2: A write with `cfg_sel`=0 (set-enable) enables each source whose `cfg_data` bit is 1. Bits written as 0 leave their enable unchanged.
- R3: A write with `cfg_sel`=1 (clear-enable) disables each source whose `cfg_data` bit is 1. Bits written as 0 leave their enable unchanged. Disabling the presented source withdraws the request.
- R4: The presented `exc_num` equals the source index plus 16. `vec_addr` equals `exc_num` times 4, so source 18 gives 34 and 0x88. When no request is presented, both outputs are 0.
- R5: Among qualifying sources, the one with the numerically smallest priority wins. Equal priorities resolve to the lowest index.
- R6: A write with `cfg_sel`=2 stores `cfg_data[4:0]` as the priority of source `cfg_idx`. Priorities reset to 0.
- R7: A write with `cfg_sel`=3 stores `cfg_data[0]` as the global mask. While the mask is 1, no request is presented.
- R8: A write with `cfg_sel`=4 stores `cfg_data[4:0]` as the base threshold. A threshold of 0 blocks nothing. A nonzero threshold blocks every source whose priority is greater than or equal to it.
- R9: A source becomes pending on a rising edge of its `irq_in` bit. Pending stays set after the input falls. A one-cycle pulse is presented on the second rising clock edge after it is sampled.
- R10: Pulsing `ack` while a request is presented does three things: it clears that source's pending bit, it drops `req_valid` on that edge, and it holds off every request until end of service.
- R11: Pulsing `eoi` ends service. On the following edge, the best remaining pending source is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Peripheral request lines, rising-edge captured |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0 set-enable, 1 clear-enable, 2 priority, 3 global mask, 4 threshold |
| cfg_idx | input | 5 | Source index for priority writes |
| cfg_data | input | 32 | Write data |
| ack | input | 1 | Processor takes the presented request |
| eoi | input | 1 | Service of the active source has ended |
| req_valid | output | 1 | A request is presented (registered) |
| exc_num | output | 6 | Exception number of the presented source (registered) |
| vec_addr | output | 32 | Vector-table address of the presented source (registered) |

## Verification
The assertions rely on three things about the inputs: `ack` is pulsed only while `req_valid` is high, `eoi` is pulsed only while a source is in service, and `cfg_sel` carries one of the five defined codes. The stimulus keeps to these rules. Every input changes on the falling clock edge, and each input is held for exactly one rising edge. Each table entry starts from a fresh reset, so configuration left over from one entry never affects the next.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [2:0] {
    CFG_SETEN  = 3'd0,
    CFG_CLREN  = 3'd1,
    CFG_PRIO   = 3'd2,
    CFG_GMASK  = 3'd3,
    CFG_THRESH = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/irqv_cfg_regs.sv
module irqv_cfg_regs #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 5,
  parameter int IDX_W  = $clog2(N_SRC)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [2:0]                     wr_sel,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [N_SRC-1:0]               wr_data,
  output logic [N_SRC-1:0]               en_q,
  output logic [N_SRC-1:0][PRIO_W-1:0]   prio_q,
  output logic                           gmask_q,
  output logic [PRIO_W-1:0]              thresh_q
);
  import irqv_pkg::*;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      gmask_q  <= 1'b0;
      thresh_q <= '0;
    end else if (wr_en) begin
      case (sel)
        CFG_SETEN:  en_q     <= en_q | wr_data;
        CFG_CLREN:  en_q     <= en_q & ~wr_data;
        CFG_GMASK:  gmask_q  <= wr_data[0];
        CFG_THRESH: thresh_q <= wr_data[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SRC; i++) begin
      if (rst)
        prio_q[i] <= '0;
      else if (wr_en && sel == CFG_PRIO && wr_idx == IDX_W'(i))
        prio_q[i] <= wr_data[PRIO_W-1:0];
    end
  end

  // R2: written ones become enabled, written zeros keep their old value
  p_set_ones_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == CFG_SETEN) |=> ((en_q & $past(wr_data)) == $past(wr_data)));
  p_set_zeros_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == CFG_SETEN) |=> ((en_q & ~$past(wr_data)) == ($past(en_q) & ~$past(wr_data))));
  // R3: written ones become disabled
  p_clr_ones_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == CFG_CLREN) |=> ((en_q & $past(wr_data)) == '0));
  // R6: a priority write lands in the addressed slot
  p_prio_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == CFG_PRIO) |=> (prio_q[$past(wr_idx)] == $past(wr_data[PRIO_W-1:0])));
endmodule

// File: rtl/irqv_pend.sv
module irqv_pend #(
  parameter int N_SRC = 32,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N_SRC-1:0] pend_q
);
  logic [N_SRC-1:0] irq_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] clr_mask;

  assign rise = irq_in & ~irq_q;

  always_comb begin
    clr_mask = '0;
    if (clr_valid) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= (pend_q & ~clr_mask) | rise;
    end
  end

  // R9: a captured edge stays pending on the next cycle
  p_edge_latched_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_in != '0 && (irq_in & ~irq_q) != '0) |=> ((pend_q & $past(irq_in & ~irq_q)) == $past(irq_in & ~irq_q)));
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 5,
  parameter int IDX_W  = $clog2(N_SRC)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_SRC-1:0]             pend,
  input  logic [N_SRC-1:0]             en,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                         gmask,
  input  logic [PRIO_W-1:0]            thresh,
  input  logic                         busy,
  output logic                         win_valid,
  output logic [IDX_W-1:0]             win_idx
);
  logic [N_SRC-1:0] below_thr;
  logic [N_SRC-1:0] cand;
  logic [PRIO_W-1:0] best_p;

  for (genvar g = 0; g < N_SRC; g++) begin : g_thr
    assign below_thr[g] = (thresh == '0) || (prio[g] < thresh);
  end

  assign cand = pend & en & below_thr & {N_SRC{~gmask & ~busy}};

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_p    = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!win_valid || prio[i] < best_p)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best_p    = prio[i];
      end
    end
  end

  // R5: no qualifying source beats the winner, ties go to the lower index
  always_ff @(posedge clk) begin
    if (!rst && win_valid) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (cand[i]) begin
          p_best_prio_r5: assert (prio[win_idx] < prio[i] ||
                                  (prio[win_idx] == prio[i] && win_idx <= IDX_W'(i)))
            else $error("arbiter picked a worse source");
        end
      end
    end
  end

  // R8: a winner under a nonzero threshold lies strictly below it
  p_thresh_r8: assert property (@(posedge clk) disable iff (rst)
    (win_valid && thresh != '0) |-> (prio[win_idx] < thresh));
  // R1: only enabled sources win
  p_win_enabled_r1: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> en[win_idx]);
endmodule

// File: rtl/irqv_out_stage.sv
module irqv_out_stage #(
  parameter int N_SRC    = 32,
  parameter int IDX_W    = $clog2(N_SRC),
  parameter int EXC_BASE = 16,
  parameter int EXC_W    = 6,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              ack,
  input  logic              eoi,
  output logic              req_valid,
  output logic [EXC_W-1:0]  exc_num,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              busy_q,
  output logic              clr_valid,
  output logic [IDX_W-1:0]  clr_idx
);
  logic              ack_fire;
  logic              take;
  logic [IDX_W-1:0]  cur_idx_q;
  logic [EXC_W-1:0]  exc_next;
  logic [ADDR_W-1:0] vec_next;

  assign ack_fire  = ack & req_valid;
  assign take      = win_valid & ~ack_fire;
  assign clr_valid = ack_fire;
  assign clr_idx   = cur_idx_q;
  assign exc_next  = EXC_W'(EXC_BASE) + EXC_W'(win_idx);
  assign vec_next  = {{(ADDR_W-EXC_W-2){1'b0}}, exc_next, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      req_valid <= 1'b0;
      cur_idx_q <= '0;
      exc_num   <= '0;
      vec_addr  <= '0;
    end else begin
      if (ack_fire)  busy_q <= 1'b1;
      else if (eoi)  busy_q <= 1'b0;
      req_valid <= take;
      if (take) begin
        cur_idx_q <= win_idx;
        exc_num   <= exc_next;
        vec_addr  <= vec_next;
      end else begin
        exc_num   <= '0;
        vec_addr  <= '0;
      end
    end
  end

  // R4: presented numbers stay inside the peripheral range
  p_exc_range_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (exc_num >= EXC_W'(EXC_BASE) && exc_num < EXC_W'(EXC_BASE + N_SRC)));
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (exc_num == '0 && vec_addr == '0));
  // R10: a taken request is withdrawn on the next edge
  p_ack_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && req_valid) |=> (!req_valid && busy_q));
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int N_SRC    = 32,
  parameter int PRIO_W   = 5,
  parameter int IDX_W    = $clog2(N_SRC),
  parameter int EXC_BASE = 16,
  parameter int EXC_W    = 6,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [N_SRC-1:0]  cfg_data,
  input  logic              ack,
  input  logic              eoi,
  output logic              req_valid,
  output logic [EXC_W-1:0]  exc_num,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [N_SRC-1:0]             en_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic                         gmask_q;
  logic [PRIO_W-1:0]            thresh_q;
  logic [N_SRC-1:0]             pend_q;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;
  logic                         busy_q;
  logic                         clr_valid;
  logic [IDX_W-1:0]             clr_idx;

  irqv_cfg_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_idx(cfg_idx),
    .wr_data(cfg_data), .en_q(en_q), .prio_q(prio_q), .gmask_q(gmask_q),
    .thresh_q(thresh_q));

  irqv_pend #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .clr_valid(clr_valid),
    .clr_idx(clr_idx), .pend_q(pend_q));

  irqv_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .pend(pend_q), .en(en_q), .prio(prio_q),
    .gmask(gmask_q), .thresh(thresh_q), .busy(busy_q),
    .win_valid(win_valid), .win_idx(win_idx));

  irqv_out_stage #(.N_SRC(N_SRC), .IDX_W(IDX_W), .EXC_BASE(EXC_BASE),
                   .EXC_W(EXC_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_idx(win_idx),
    .ack(ack), .eoi(eoi), .req_valid(req_valid), .exc_num(exc_num),
    .vec_addr(vec_addr), .busy_q(busy_q), .clr_valid(clr_valid),
    .clr_idx(clr_idx));

  // R10: nothing is presented while a source is in service
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !req_valid);
  // R7: the global mask silences the output on the next edge
  p_gmask_r7: assert property (@(posedge clk) disable iff (rst)
    gmask_q |=> !req_valid);
endmodule

// File: tb/irqv_top_bench.sv
module irqv_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;
  logic        req_valid;
  logic [5:0]  exc_num;
  logic [31:0] vec_addr;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irqv_top u_irqv_top (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .ack(ack), .eoi(eoi),
    .req_valid(req_valid), .exc_num(exc_num), .vec_addr(vec_addr));

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] irq;
    logic [4:0]  thr;
    logic        exp_v;
    logic [5:0]  exp_exc;
  } vec_t;

  // priorities in every entry are programmed as index mod 8
  localparam vec_t TBL [10] = '{
    '{32'h0000_0000, 32'h0004_0000, 5'd0, 1'b0, 6'd0},   // R1 disabled source
    '{32'h0004_0000, 32'h0004_0000, 5'd0, 1'b1, 6'd34},  // R2 R4 source 18
    '{32'hFFFF_FFFF, 32'h0000_0108, 5'd0, 1'b1, 6'd24},  // R5 prio 0 beats 3
    '{32'hFFFF_FFFF, 32'h0001_0100, 5'd0, 1'b1, 6'd24},  // R5 tie, lower index
    '{32'hFFFF_FFFF, 32'h0000_2020, 5'd0, 1'b1, 6'd21},  // R5 tie at prio 5
    '{32'hFFFF_FFFF, 32'h0000_0024, 5'd4, 1'b1, 6'd18},  // R8 prio 5 blocked
    '{32'hFFFF_FFFF, 32'h0000_0010, 5'd4, 1'b0, 6'd0},   // R8 equal blocked
    '{32'hFFFF_FFFF, 32'h0000_0001, 5'd1, 1'b1, 6'd16},  // R8 prio 0 under 1
    '{32'hFFFF_FFFF, 32'h8000_0000, 5'd0, 1'b1, 6'd47},  // R4 top source
    '{32'hFFFF_FFFB, 32'h0000_0084, 5'd0, 1'b1, 6'd23}   // R2 only enabled wins
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic v, input logic [5:0] e);
    check({req, " valid"}, 32'(req_valid), 32'(v));
    check({req, " exc"}, 32'(exc_num), v ? 32'(e) : 32'd0);
    check({req, " vec"}, vec_addr, v ? 32'(e) * 32'd4 : 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0;
  endtask

  task automatic pulse_irq(input logic [31:0] m);
    @(negedge clk); irq_in = m;
    @(negedge clk); irq_in = '0;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check_out("R1 reset", 1'b0, 6'd0);

    for (int t = 0; t < 10; t++) begin
      do_reset();
      cfg(3'd0, 5'd0, TBL[t].en);
      for (int i = 0; i < 32; i++) cfg(3'd2, 5'(i), 32'(i % 8));
      cfg(3'd4, 5'd0, 32'(TBL[t].thr));
      pulse_irq(TBL[t].irq);
      check_out($sformatf("table %0d", t), TBL[t].exp_v, TBL[t].exp_exc);
    end

    // R6: default priorities are all 0, so lowest index wins
    do_reset();
    cfg(3'd0, 5'd0, 32'hFFFF_FFFF);
    pulse_irq(32'h0000_0208);
    check_out("R6 default prio", 1'b1, 6'd19);
    // R10: ack drops request and holds off source 9
    pulse_ack();
    check_out("R10 after ack", 1'b0, 6'd0);
    @(negedge clk); @(negedge clk);
    check_out("R10 held off", 1'b0, 6'd0);
    // R11: end of service presents the remaining source
    pulse_eoi();
    @(negedge clk);
    check_out("R11 next source", 1'b1, 6'd25);
    pulse_ack();
    pulse_eoi();
    @(negedge clk); @(negedge clk);
    check_out("R10 pending cleared", 1'b0, 6'd0);

    // R7: global mask
    do_reset();
    cfg(3'd0, 5'd0, 32'hFFFF_FFFF);
    cfg(3'd3, 5'd0, 32'd1);
    pulse_irq(32'h0000_0001);
    check_out("R7 masked", 1'b0, 6'd0);
    cfg(3'd3, 5'd0, 32'd0);
    @(negedge clk);
    check_out("R7 unmasked", 1'b1, 6'd16);

    // R2 R3: zero writes have no effect, one writes disable
    do_reset();
    cfg(3'd0, 5'd0, 32'h0000_0010);
    cfg(3'd0, 5'd0, 32'h0000_0000);
    pulse_irq(32'h0000_0010);
    check_out("R2 zero write kept", 1'b1, 6'd20);
    cfg(3'd1, 5'd0, 32'h0000_0000);
    @(negedge clk);
    check_out("R3 zero clear kept", 1'b1, 6'd20);
    cfg(3'd1, 5'd0, 32'h0000_0010);
    @(negedge clk);
    check_out("R3 cleared", 1'b0, 6'd0);
    cfg(3'd0, 5'd0, 32'h0000_0010);
    @(negedge clk);
    check_out("R9 pending kept while disabled", 1'b1, 6'd20);

    // R6 R5: reprogrammed priority changes the winner
    cfg(3'd0, 5'd0, 32'h0000_0800);
    cfg(3'd2, 5'd4, 32'd9);
    cfg(3'd2, 5'd11, 32'd2);
    pulse_irq(32'h0000_0800);
    check_out("R6 prio write", 1'b1, 6'd27);

    // R1: reset while presenting
    do_reset();
    @(negedge clk);
    check_out("R1 reset clears", 1'b0, 6'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule